// File: doc/BRIEF.md
# Externally Clocked Serial Shift-Out Register

This block holds one byte and sends it out one bit at a time on a serial line. A pulse input that is not related to the system clock sets the pace. The pulse line is brought into the system clock domain, and each rising edge found there rotates the byte left by one place. The most significant bit is sent first, and it also wraps round into bit 0. The serial line always shows the current top bit of the byte.

A group state machine counts the detected pulses in groups of eight. At the end of each group it raises a completion flag and gives a one-cycle set pulse, which an interrupt flag unit can use. Shifting carries on after the flag is raised. Each further group of eight pulses gives another set pulse. Any host read or write of the register clears the flag and starts the group count again. If a host access and a detected pulse edge fall in the same cycle, the access wins and that edge is dropped.

The state machine has two states. `ST_RUN` means a group is in progress and the flag is clear. `ST_FULL` means the flag is set. There are four transitions:

| Transition | From | To | When |
|---|---|---|---|
| `T_WRAP` | `ST_RUN` | `ST_FULL` | the eighth pulse of a group arrives |
| `T_REWRAP` | `ST_FULL` | `ST_FULL` | another eighth pulse arrives |
| `T_ACK` | `ST_FULL` | `ST_RUN` | the host accesses the register |
| `T_RESTART` | `ST_RUN` | `ST_RUN` | the host accesses the register during a group |

Top module: `xclk_shift_out`

## Requirements
- R1: After reset, `done_flag`, `done_set`, `host_rdata` and `sdata_out` are all 0.
- R2: A host write (`host_wr`=1 at a clock edge) loads `host_wdata`, and the byte appears on `host_rdata` after that edge.
- R3: Each rising edge on `xclk_in` rotates the held byte left by one place: bit 7 moves into bit 0 and every other bit moves up one place. The new value shows at the third system clock edge after `xclk_in` is first sampled high.
- R4: `sdata_out` always equals bit 7 of the held byte, and it holds that value between pulses.
- R5: After seven pulses counted since reset or since the last host access, `done_flag` is still 0. The eighth pulse sets `done_flag` to 1 and gives exactly one `done_set` pulse, one clock wide.
- R6: Reaching a count of eight does not stop shifting. While `done_flag` stays 1, each further group of eight pulses gives one more single-cycle `done_set` pulse.
- R7: A host read (`host_rd`=1) clears `done_flag` and starts the group count again. It leaves the held byte unchanged.
- R8: A host write also clears `done_flag` and starts the group count again.
- R9: If a host access and a detected pulse edge fall in the same cycle, that edge is neither shifted nor counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe; loads the byte |
| host_rd | input | 1 | Host read strobe; clears the flag and the group count |
| host_wdata | input | 8 | Byte to load |
| host_rdata | output | 8 | Current held byte |
| xclk_in | input | 1 | External shift pulse, asynchronous to `clk` |
| sdata_out | output | 1 | Serial data out, equal to the current bit 7 |
| done_set | output | 1 | One-cycle pulse at the end of each group of eight |
| done_flag | output | 1 | Completion flag level |

## Verification
A wrong group count shows at the ports as a `done_flag` or `done_set` that comes one or more pulses early or late. The bench catches this within the same group of eight pulses. A shift that is dropped or applied twice changes `host_rdata` and `sdata_out`, and this shows three clock edges after the offending pulse. A flag left set, or a count left unrestarted, after a host access moves the next completion off the eighth pulse after that access. The bench loads every byte value, runs sixteen pulses on each, and checks the rotation and the flag after every pulse.

// File: rtl/xso_pkg.sv
package xso_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_FULL = 1'b1
    } xso_state_t;
endpackage

// File: rtl/xso_edge_sync.sv
module xso_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= async_in;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;

    // R3: a detected edge lasts one cycle only
    a_r3_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/xso_shifter.sv
module xso_shifter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] wdata,
    input  logic             shift_en,
    output logic [WIDTH-1:0] data,
    output logic             sdata
);
    logic [WIDTH-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        data_q <= '0;
        else if (load)     data_q <= wdata;
        else if (shift_en) data_q <= {data_q[WIDTH-2:0], data_q[WIDTH-1]};
    end

    assign data  = data_q;
    assign sdata = data_q[WIDTH-1];

    // R2
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> data == $past(wdata));
    // R3: the outgoing bit wraps round into bit 0
    a_r3_recirc: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !load) |=> sdata == $past(data[WIDTH-2]) && data[0] == $past(sdata));
    // R4: nothing changes without a load or a shift
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !load) |=> $stable(data));
endmodule

// File: rtl/xso_group_fsm.sv
module xso_group_fsm
    import xso_pkg::*;
#(
    parameter int GROUP = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic edge_det,
    output logic shift_en,
    output logic flag,
    output logic set_pulse
);
    localparam int CW = (GROUP > 1) ? $clog2(GROUP) : 1;
    localparam logic [CW-1:0] LAST = CW'(GROUP - 1);

    xso_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          wrap;

    // A host access beats an edge in the same cycle
    assign shift_en = edge_det & ~access;
    assign wrap     = shift_en && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (access) begin
            cnt_d = '0;
        end else if (shift_en) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
        unique case (state_q)
            ST_RUN: begin
                if (wrap) state_d = ST_FULL;           // T_WRAP
                else      state_d = ST_RUN;            // T_RESTART or hold
            end
            ST_FULL: begin
                if (access) state_d = ST_RUN;          // T_ACK
                else        state_d = ST_FULL;         // T_REWRAP or hold
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag      <= 1'b0;
            set_pulse <= 1'b0;
        end else begin
            flag      <= (state_d == ST_FULL);
            set_pulse <= wrap;
        end
    end

    // R5: the set pulse is one cycle wide
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |=> !set_pulse);
    // R5: the flag rises only together with a set pulse
    a_r5_rise_with_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> set_pulse);
    // R6: a set pulse always leaves the flag set
    a_r6_flag_after_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_pulse |-> flag);
    // R7, R8
    a_r7_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !flag && !set_pulse);
    // R9
    a_r9_access_blocks_shift: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> !shift_en);
endmodule

// File: rtl/xclk_shift_out.sv
module xclk_shift_out #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              xclk_in,
    output logic              sdata_out,
    output logic              done_set,
    output logic              done_flag
);
    logic rise;
    logic access;
    logic shift_en;

    assign access = host_wr | host_rd;

    xso_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (xclk_in),
        .rise     (rise)
    );

    xso_group_fsm #(.GROUP(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .access    (access),
        .edge_det  (rise),
        .shift_en  (shift_en),
        .flag      (done_flag),
        .set_pulse (done_set)
    );

    xso_shifter #(.WIDTH(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (host_wr),
        .wdata    (host_wdata),
        .shift_en (shift_en),
        .data     (host_rdata),
        .sdata    (sdata_out)
    );

    // R4
    a_r4_serial_is_msb: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_out == host_rdata[DATA_W-1]);
endmodule

// File: tb/test_xclk_shift_out.sv
module test_xclk_shift_out;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       xclk_in = 1'b0;
    logic       sdata_out, done_set, done_flag;

    int n_cmp = 0, n_bad = 0;
    int sets_seen = 0;
    logic [7:0] exp_q;

    always #10 clk = ~clk;

    xclk_shift_out i_xclk_shift_out (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .xclk_in(xclk_in),
        .sdata_out(sdata_out), .done_set(done_set), .done_flag(done_flag)
    );

    always @(negedge clk) if (done_set) sets_seen++;

    task automatic chk(input string req, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] rotl(input logic [7:0] v);
        return {v[6:0], v[7]};
    endfunction

    task automatic pulse();
        xclk_in = 1'b1;
        repeat (4) @(negedge clk);
        xclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] v);
        host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read();
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 flag", done_flag, 0);
        chk("R1 set", done_set, 0);
        chk("R1 data", host_rdata, 0);
        chk("R1 sdata", sdata_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            host_write(8'(v));
            exp_q = 8'(v);
            chk("R2 load", host_rdata, v);
            chk("R8 flag cleared by write", done_flag, 0);
            sets_seen = 0;
            for (int p = 1; p <= 16; p++) begin
                pulse();
                exp_q = rotl(exp_q);
                chk("R3 rotate", host_rdata, exp_q);
                chk("R4 sdata", sdata_out, exp_q[7]);
                if (p < 8) chk("R5 flag early", done_flag, 0);
                else       chk("R6 flag stays", done_flag, 1);
                chk("R5/R6 set count", sets_seen, p / 8);
            end
        end

        // R4: the output holds between pulses
        host_write(8'h80);
        repeat (10) @(negedge clk);
        chk("R4 hold sdata", sdata_out, 1);
        chk("R4 hold data", host_rdata, 8'h80);

        // R7: a read clears the flag, keeps the data, restarts the count
        for (int p = 0; p < 8; p++) pulse();
        chk("R5 flag after 8", done_flag, 1);
        for (int p = 0; p < 3; p++) pulse();
        exp_q = 8'h04;           // 0x80 rotated 11 times
        chk("R3 data before read", host_rdata, exp_q);
        host_read();
        chk("R7 flag cleared", done_flag, 0);
        chk("R7 data kept", host_rdata, exp_q);
        sets_seen = 0;
        for (int p = 1; p <= 8; p++) begin
            pulse();
            chk("R7 restart flag", done_flag, p == 8 ? 1 : 0);
        end
        chk("R7 one set", sets_seen, 1);

        // R9: an edge in the same cycle as an access is dropped
        host_write(8'hC1);
        exp_q = 8'hC1;
        xclk_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        host_rd = 1'b1;          // access meets the detected edge
        @(negedge clk);
        host_rd = 1'b0;
        repeat (2) @(negedge clk);
        xclk_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 no shift", host_rdata, exp_q);
        sets_seen = 0;
        for (int p = 1; p <= 8; p++) begin
            pulse();
            exp_q = rotl(exp_q);
            chk("R9 not counted flag", done_flag, p == 8 ? 1 : 0);
        end
        chk("R9 data", host_rdata, exp_q);
        chk("R9 one set", sets_seen, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule